// File: doc/BRIEF.md
# Multi-Line Page Write Cache

This block stages bytes written over a serial memory bus before they are programmed into a nonvolatile array. The protocol engine gives it three things in order. First it loads a 13-bit start address. Next it sends one strobe per received data byte. Last it sends a STOP strobe. The start address splits into two parts. The upper seven bits select the array page and stay fixed for the whole transfer. The lower six bits start a pointer into a 64-byte cache, which is arranged as eight lines of eight bytes.

Each data byte is stored at the pointer, and then the pointer advances. When it passes the last byte of a line, it moves on to the next line. When it passes byte 63, it wraps to byte 0, and any further bytes overwrite earlier ones. The cache also keeps a valid bit for every byte.

STOP starts a commit. The block scans the cache in ascending index order. For every valid byte it emits one write on a simple byte-write port, using the address formed from the page and the cache index. A busy flag stays high for a fixed, parameterised number of cycles. An abort input, for example a repeated START, discards the captured bytes without writing any of them.

Top module: `page_write_cache`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and the valid mask is empty, so a STOP with no bytes written produces no array writes.
- R2: An accepted `addr_load` stores `addr_in[12:6]` as the page and `addr_in[5:0]` as the cache pointer, and it clears every valid bit.
- R3: Each accepted `data_stb` writes `data_in` to the cache byte at the pointer, sets that byte's valid bit and adds one to the six-bit pointer. Going from offset 7 of a line to offset 0 moves the pointer to the next line, and the page never changes.
- R4: After cache byte 63 the pointer wraps to byte 0. More than 64 bytes before STOP overwrite the earliest bytes, and each overwritten byte keeps its latest value.
- R5: An accepted `stop_stb` commits only the valid bytes, one per cycle on `arr_we`, in ascending cache index. Each write uses `arr_addr = {page, index}` and `arr_data` = the stored byte. `arr_we` is never high while `busy` is low.
- R6: `busy` goes high on the cycle after an accepted STOP. It stays high for exactly `BUSY_CYCLES` cycles, which must be at least 64.
- R7: While `busy` is high, `addr_load`, `data_stb`, `stop_stb` and `abort_stb` have no effect. A later STOP with no new load commits the same bytes again.
- R8: An accepted `abort_stb` clears the valid mask and writes nothing to the array. When strobes coincide, the priority is abort, then stop, then address load, then data.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address strobe |
| addr_in | input | 13 | Start word address |
| data_stb | input | 1 | Data byte received strobe |
| data_in | input | 8 | Received data byte |
| stop_stb | input | 1 | STOP received, start commit |
| abort_stb | input | 1 | Abort transfer, drop captured bytes |
| busy | output | 1 | Commit in progress |
| arr_we | output | 1 | Array byte write enable |
| arr_addr | output | 13 | Array byte address |
| arr_data | output | 8 | Array byte data |

## Verification
The bench drives several patterns and compares the writes logged on the array port with the list that the requirements predict.

- A single byte checks address composition.
- A short run starting at offset 6 crosses a line boundary, which shows that the pointer carries into the line number.
- A run starting at byte 62 crosses the cache end, which shows that the carry stops before the page bits. It also shows that commit order follows cache index rather than arrival order.
- A 66-byte run tells overwrite apart from stopping at a full cache.
- Three further patterns probe the mask. An abort before STOP, a reload after some bytes, and strobes sent during busy followed by a repeated STOP each show whether the mask is cleared or kept.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_COMMIT = 1'b1
   } phase_e;

   // Strobe decode after priority and busy gating
   typedef struct packed {
      logic abort;
      logic stop;
      logic load;
      logic data;
   } ev_t;
endpackage

// File: rtl/pgc_ptr.sv
module pgc_ptr #(
   parameter int ADDR_W = 13,
   parameter int PTR_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        addr_in,
   input  logic                     adv,
   output logic [ADDR_W-PTR_W-1:0]  page,
   output logic [PTR_W-1:0]         ptr
);
   localparam int PAGE_W = ADDR_W - PTR_W;

   if (PAGE_W < 1) begin : g_bad_width
      $error("pgc_ptr: ADDR_W must exceed PTR_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= '0;
         ptr  <= '0;
      end else if (load) begin
         page <= addr_in[ADDR_W-1:PTR_W];
         ptr  <= addr_in[PTR_W-1:0];
      end else if (adv) begin
         ptr  <= ptr + 1'b1;   // six-bit wrap, page untouched
      end
   end
endmodule

// File: rtl/pgc_store.sv
module pgc_store #(
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 8,
   parameter int NUM_LINES  = 8
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       clr,
   input  logic                                       wr,
   input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0]    wr_idx,
   input  logic [DATA_W-1:0]                          wr_data,
   input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0]    rd_idx,
   output logic [DATA_W-1:0]                          rd_data,
   output logic                                       rd_valid
);
   localparam int CACHE_BYTES = LINE_BYTES * NUM_LINES;
   localparam int OFF_W       = $clog2(LINE_BYTES);
   localparam int IDX_W       = $clog2(CACHE_BYTES);

   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("pgc_store: LINE_BYTES must be a power of two");
   end
   if ((1 << IDX_W) != CACHE_BYTES) begin : g_bad_lines
      $error("pgc_store: NUM_LINES must be a power of two");
   end

   logic [CACHE_BYTES-1:0][DATA_W-1:0] data_flat;
   logic [CACHE_BYTES-1:0]             vld_flat;

   for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
      logic [LINE_BYTES-1:0][DATA_W-1:0] line_mem;
      logic [LINE_BYTES-1:0]             line_vld;
      logic                              hit;

      assign hit = wr && (wr_idx[IDX_W-1:OFF_W] == ln[IDX_W-OFF_W-1:0]);

      always_ff @(posedge clk) begin
         if (hit) line_mem[wr_idx[OFF_W-1:0]] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        line_vld <= '0;
         else if (clr)      line_vld <= '0;
         else if (hit)      line_vld[wr_idx[OFF_W-1:0]] <= 1'b1;
      end

      assign data_flat[ln*LINE_BYTES +: LINE_BYTES] = line_mem;
      assign vld_flat[ln*LINE_BYTES +: LINE_BYTES]  = line_vld;
   end

   assign rd_data  = data_flat[rd_idx];
   assign rd_valid = vld_flat[rd_idx];
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq #(
   parameter int BUSY_CYCLES = 80,
   parameter int CACHE_BYTES = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   output logic                           busy,
   output logic                           scan_on,
   output logic [$clog2(CACHE_BYTES)-1:0] scan_idx
);
   import pgc_pkg::*;

   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam int IDX_W = $clog2(CACHE_BYTES);

   if (BUSY_CYCLES < CACHE_BYTES) begin : g_bad_busy
      $error("pgc_seq: BUSY_CYCLES must cover one scan of the cache");
   end

   phase_e           phase;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            phase <= PH_COMMIT;
            cnt   <= '0;
         end
      end else if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign busy     = (phase == PH_COMMIT);
   assign scan_on  = busy && (cnt < CNT_W'(CACHE_BYTES));
   assign scan_idx = cnt[IDX_W-1:0];
endmodule

// File: rtl/page_write_cache.sv
module page_write_cache #(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 8,
   parameter int LINE_BYTES  = 8,
   parameter int NUM_LINES   = 8,
   parameter int BUSY_CYCLES = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              data_stb,
   input  logic [DATA_W-1:0] data_in,
   input  logic              stop_stb,
   input  logic              abort_stb,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data
);
   import pgc_pkg::*;

   localparam int CACHE_BYTES = LINE_BYTES * NUM_LINES;
   localparam int PTR_W       = $clog2(CACHE_BYTES);
   localparam int PAGE_W      = ADDR_W - PTR_W;

   if (PAGE_W < 1) begin : g_bad_addr
      $error("page_write_cache: address too narrow for cache");
   end

   ev_t               ev;
   logic [PAGE_W-1:0] page;
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  scan_idx;
   logic              scan_on;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;

   // Priority: abort > stop > load > data, all gated by busy
   always_comb begin
      ev.abort = abort_stb && !busy;
      ev.stop  = stop_stb  && !busy && !abort_stb;
      ev.load  = addr_load && !busy && !abort_stb && !stop_stb;
      ev.data  = data_stb  && !busy && !abort_stb && !stop_stb && !addr_load;
   end

   pgc_ptr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ev.load),
      .addr_in (addr_in),
      .adv     (ev.data),
      .page    (page),
      .ptr     (ptr)
   );

   pgc_store #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ev.abort || ev.load),
      .wr       (ev.data),
      .wr_idx   (ptr),
      .wr_data  (data_in),
      .rd_idx   (scan_idx),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   pgc_seq #(.BUSY_CYCLES(BUSY_CYCLES), .CACHE_BYTES(CACHE_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (ev.stop),
      .busy     (busy),
      .scan_on  (scan_on),
      .scan_idx (scan_idx)
   );

   assign arr_we   = scan_on && rd_valid;
   assign arr_addr = {page, scan_idx};
   assign arr_data = rd_data;
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 8,
   parameter int PTR_W       = 6,
   parameter int BUSY_CYCLES = 80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_load,
   input logic [ADDR_W-1:0] addr_in,
   input logic              stop_stb,
   input logic              abort_stb,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 2);

   logic [ADDR_W-PTR_W-1:0] page_q;
   logic [PTR_W-1:0]        last_idx;
   logic                    seen;
   logic [CNT_W-1:0]        blen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q   <= '0;
         last_idx <= '0;
         seen     <= 1'b0;
         blen     <= '0;
      end else begin
         if (addr_load && !busy && !abort_stb && !stop_stb)
            page_q <= addr_in[ADDR_W-1:PTR_W];
         if (stop_stb && !busy && !abort_stb) begin
            seen <= 1'b0;
         end else if (arr_we) begin
            seen     <= 1'b1;
            last_idx <= arr_addr[PTR_W-1:0];
         end
         blen <= busy ? blen + 1'b1 : '0;
      end
   end

   assert_we_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (arr_addr[ADDR_W-1:PTR_W] == page_q));
   assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && seen) |-> (arr_addr[PTR_W-1:0] > last_idx));
   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_stb && !abort_stb && !busy) |=> busy);
   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (blen == CNT_W'(BUSY_CYCLES)));
   assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_stb && !busy) |=> !arr_we);
endmodule

bind page_write_cache pgc_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
   .stop_stb(stop_stb), .abort_stb(abort_stb), .busy(busy),
   .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/page_write_cache_bench.sv
module page_write_cache_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BUSY_N     = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_load = 1'b0;
   logic [12:0] addr_in = '0;
   logic        data_stb = 1'b0;
   logic [7:0]  data_in = '0;
   logic        stop_stb = 1'b0;
   logic        abort_stb = 1'b0;
   logic        busy, arr_we;
   logic [12:0] arr_addr;
   logic [7:0]  arr_data;

   int n_chk = 0;
   int n_fail = 0;
   int log_n = 0;
   logic [12:0] log_addr [0:127];
   logic [7:0]  log_data [0:127];
   int busy_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   page_write_cache #(.BUSY_CYCLES(BUSY_N)) u_page_write_cache (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .data_stb(data_stb), .data_in(data_in), .stop_stb(stop_stb),
      .abort_stb(abort_stb), .busy(busy), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_data(arr_data)
   );

   always @(negedge clk) begin
      if (arr_we && log_n < 128) begin
         log_addr[log_n] = arr_addr;
         log_data[log_n] = arr_data;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic do_load(input logic [12:0] a);
      @(negedge clk); addr_load = 1'b1; addr_in = a;
      @(negedge clk); addr_load = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      @(negedge clk); data_stb = 1'b1; data_in = d;
      @(negedge clk); data_stb = 1'b0;
   endtask

   task automatic do_abort();
      @(negedge clk); abort_stb = 1'b1;
      @(negedge clk); abort_stb = 1'b0;
   endtask

   // STOP, then wait out busy counting its length; log holds the commit
   task automatic do_stop();
      @(negedge clk); log_n = 0; stop_stb = 1'b1;
      @(negedge clk); stop_stb = 1'b0;
      busy_len = 0;
      while (busy && busy_len < 1000) begin
         busy_len++;
         @(negedge clk);
      end
   endtask

   task automatic expect_one(input int k, input logic [12:0] a, input logic [7:0] d, input string req);
      chk(log_addr[k] == a, req, log_addr[k], a);
      chk(log_data[k] == d, req, log_data[k], d);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
      do_stop();
      chk(log_n == 0, "R1 empty mask", log_n, 0);
   endtask

   task automatic t_single();
      do_load(13'h1A3D);
      do_byte(8'h5A);
      do_stop();
      chk(busy_len == BUSY_N, "R6 busy length", busy_len, BUSY_N);
      chk(log_n == 1, "R5 count", log_n, 1);
      expect_one(0, 13'h1A3D, 8'h5A, "R2 single");
   endtask

   task automatic t_line_cross();
      do_load(13'h0106);
      for (int i = 0; i < 4; i++) do_byte(8'hA0 + 8'(i));
      do_stop();
      chk(log_n == 4, "R3 count", log_n, 4);
      for (int i = 0; i < 4; i++) expect_one(i, 13'h0106 + 13'(i), 8'hA0 + 8'(i), "R3 line cross");
   endtask

   task automatic t_cache_end();
      do_load(13'h0ABE);   // page 0x2A, ptr 62
      do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
      do_stop();
      chk(log_n == 3, "R4 count", log_n, 3);
      expect_one(0, 13'h0A80, 8'h33, "R4 wrap keeps page");
      expect_one(1, 13'h0ABE, 8'h11, "R5 ascending");
      expect_one(2, 13'h0ABF, 8'h22, "R5 ascending");
   endtask

   task automatic t_overflow();
      int bad = 0;
      do_load(13'h0C40);
      for (int i = 0; i < 66; i++) do_byte(8'(i));
      do_stop();
      chk(log_n == 64, "R4 overflow count", log_n, 64);
      for (int i = 0; i < 64; i++) begin
         if (log_addr[i] != (13'h0C40 | 13'(i))) bad++;
         if (log_data[i] != ((i < 2) ? 8'(64 + i) : 8'(i))) bad++;
      end
      chk(bad == 0, "R4 overwrite", bad, 0);
      chk(log_data[0] == 8'd64, "R4 byte0 latest", log_data[0], 64);
   endtask

   task automatic t_abort();
      do_load(13'h0300);
      do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
      do_abort();
      do_stop();
      chk(log_n == 0, "R8 abort drops", log_n, 0);
      chk(busy_len == BUSY_N, "R6 busy after empty stop", busy_len, BUSY_N);
   endtask

   task automatic t_reload();
      do_load(13'h0400);
      do_byte(8'h77); do_byte(8'h78);
      do_load(13'h040A);
      do_byte(8'h99);
      do_stop();
      chk(log_n == 1, "R2 reload clears mask", log_n, 1);
      expect_one(0, 13'h040A, 8'h99, "R2 reload");
   endtask

   task automatic t_busy_ignore();
      do_load(13'h0555);
      do_byte(8'hC3);
      @(negedge clk); log_n = 0; stop_stb = 1'b1;
      @(negedge clk); stop_stb = 1'b0;
      addr_load = 1'b1; addr_in = 13'h1FF0;
      @(negedge clk); addr_load = 1'b0; data_stb = 1'b1; data_in = 8'hEE;
      @(negedge clk); data_stb = 1'b0; abort_stb = 1'b1;
      @(negedge clk); abort_stb = 1'b0;
      while (busy) @(negedge clk);
      do_stop();
      chk(log_n == 1, "R7 ignored while busy", log_n, 1);
      expect_one(0, 13'h0555, 8'hC3, "R7 recommit");
   endtask

   task automatic t_priority();
      do_load(13'h0600);
      do_byte(8'h44);
      @(negedge clk); abort_stb = 1'b1; stop_stb = 1'b1;
      @(negedge clk); abort_stb = 1'b0; stop_stb = 1'b0;
      chk(busy == 1'b0, "R8 abort beats stop", busy, 0);
      do_stop();
      chk(log_n == 0, "R8 priority", log_n, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_line_cross();
      t_cache_end();
      t_overflow();
      t_abort();
      t_reload();
      t_busy_ignore();
      t_priority();
      report();
   end
endmodule